// File: doc/BRIEF.md
# Video Raster Flywheel with Fast Relock

This block tracks the sample and line position of a high-definition raster with two free-running counters. It keeps them in phase with the timing reference codes carried on the luma half of a 20-bit video stream. Each received reference code is compared with the position the counters predict for it. In normal running the counters are re-phased only after a run of consecutive lines in which the end-of-active-video code arrived somewhere other than predicted, so isolated bit errors do not disturb the raster.

A lock flag reports when predictions and received codes have agreed for long enough. A fast-relock input is intended for a source switch: its rising edge makes the very next valid reference code re-phase the counters at once, bypassing the filter.

The outputs are registered one clock behind the input word, in step with the delayed data word:
- horizontal blanking, vertical blanking and field flags;
- the line number;
- the sample position.

An active-low synchronous reset loads the 720p raster defaults.

Top module: `video_flywheel`

## Requirements
- R1: The sample position counts 0 to TOTAL_SAMPLES-1, advancing by one each clock and wrapping to 0. The line number counts 1 to TOTAL_LINES and advances when the sample position wraps.
- R2: A reference code is valid only when three luma words 0x3FF, 0x000, 0x000 are followed by a status word with the following layout: bit 9 = 1, bits 1:0 = 0, bit 8 = F, bit 7 = V, and bit 6 = H (1 for end of active video, 0 for start). Bits 5:2 must equal V^H, F^H, F^V and F^V^H. A code failing this check has no effect on counters or lock.
- R3: The status word of an end-of-active code is predicted at sample ACTIVE_SAMPLES+3, and that of a start-of-active code at sample TOTAL_SAMPLES-1.
- R4: Without a pending fast relock, the counters are re-phased on the 4th consecutive end-of-active code found at a wrong position. A correctly placed one clears the run. Re-phasing on an end-of-active code sets the next sample position to ACTIVE_SAMPLES+4. Re-phasing on a start-of-active code sets it to 0 and advances the line.
- R5: The lock output rises on the 2nd consecutive correctly placed end-of-active code. It falls on any misplaced end-of-active code, on any re-phase and on reset.
- R6: A rising edge of fast_lock, sampled on clk, arms a relock. The next valid code of either kind then re-phases the counters immediately, regardless of the filter. Holding fast_lock high has no further effect.
- R7: With rst_n low at a clock edge, the sample position becomes 0, the line number 1, the lock output and the filter state clear, and the flags go low. The data path keeps passing words during reset.
- R8: data_out is data_in delayed by one clock. sample_pos, line_num, h_blank (sample position at least ACTIVE_SAMPLES) and v_blank (line outside FIRST_ACTIVE_LINE..LAST_ACTIVE_LINE) describe that same delayed word.
- R9: In the progressive variant (INTERLACED = 0) field stays low at all times. In the interlaced variant it is high from line FIELD2_LINE onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset to raster defaults |
| fast_lock | input | 1 | Rising edge arms an immediate relock |
| data_in | input | 20 | Luma in bits 19:10, chroma in bits 9:0 |
| data_out | output | 20 | Input word delayed by one clock |
| h_blank | output | 1 | Horizontal blanking for data_out |
| v_blank | output | 1 | Vertical blanking for data_out |
| field | output | 1 | Field flag for data_out |
| line_num | output | clog2(TOTAL_LINES+1) | Line number of data_out |
| sample_pos | output | clog2(TOTAL_SAMPLES) | Sample position of data_out |
| locked | output | 1 | Raster locked to incoming codes |

## Verification
The bench builds the block with a small progressive raster:
- 40 samples per line, 24 of them active;
- 12 lines, with active video on lines 3 to 10;
- the default filter depth of 4 lines and lock count of 2 lines.

With this raster a whole frame wrap, every line of blanking and every multi-line filter window fit into a few hundred clocks. The bench can therefore walk a full frame checking every flag word by word. It then steps through a sequence of source phase jumps, corrupted status words and fast-relock edges whose outcome is known line by line.

// File: rtl/vfw_pkg.sv
package vfw_pkg;
   localparam int unsigned WORD_W = 10;

   typedef struct packed {
      logic valid;   // complete, protected reference code seen this cycle
      logic eav;     // 1: end of active video, 0: start of active video
   } trs_evt_t;

   // protection check of the status word that closes a reference code
   function automatic logic status_word_ok(input logic [WORD_W-1:0] w);
      return w[9] && (w[1:0] == 2'b00)
          && (w[5] == (w[7] ^ w[6]))
          && (w[4] == (w[8] ^ w[6]))
          && (w[3] == (w[8] ^ w[7]))
          && (w[2] == (w[8] ^ w[7] ^ w[6]));
   endfunction
endpackage

// File: rtl/vfw_trs_detect.sv
module vfw_trs_detect
   import vfw_pkg::*;
(
   input  logic              clk,
   input  logic [WORD_W-1:0] luma,
   output trs_evt_t          evt
);
   localparam logic [WORD_W-1:0] PEAK = {WORD_W{1'b1}};
   localparam int unsigned HIST = 3;

   logic [WORD_W-1:0] hist [HIST];

   // history is part of the data path and carries no reset
   always_ff @(posedge clk) begin
      hist[0] <= luma;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
   end

   always_comb begin
      evt.valid = (hist[2] == PEAK) && (hist[1] == '0) && (hist[0] == '0)
               && status_word_ok(luma);
      evt.eav   = luma[6];
   end
endmodule

// File: rtl/vfw_raster.sv
module vfw_raster #(
   parameter int unsigned TOTAL_SAMPLES  = 1650,
   parameter int unsigned ACTIVE_SAMPLES = 1280,
   parameter int unsigned TOTAL_LINES    = 750,
   localparam int unsigned SW = $clog2(TOTAL_SAMPLES),
   localparam int unsigned LW = $clog2(TOTAL_LINES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          realign,
   input  logic          trs_eav,
   output logic          pos_match,
   output logic [SW-1:0] pos,
   output logic [LW-1:0] line
);
   localparam logic [SW-1:0] LAST_POS = SW'(TOTAL_SAMPLES - 1);
   localparam logic [SW-1:0] EAV_XYZ  = SW'(ACTIVE_SAMPLES + 3);
   localparam logic [SW-1:0] EAV_NEXT = SW'(ACTIVE_SAMPLES + 4);
   localparam logic [LW-1:0] LINE_MAX = LW'(TOTAL_LINES);
   localparam logic [LW-1:0] LINE_ONE = LW'(1);

   logic [LW-1:0] next_line;

   assign next_line = (line == LINE_MAX) ? LINE_ONE : line + 1'b1;
   assign pos_match = trs_eav ? (pos == EAV_XYZ) : (pos == LAST_POS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos  <= '0;
         line <= LINE_ONE;
      end else if (realign) begin
         if (trs_eav) pos <= EAV_NEXT;
         else begin
            pos  <= '0;
            line <= next_line;
         end
      end else if (pos == LAST_POS) begin
         pos  <= '0;
         line <= next_line;
      end else begin
         pos <= pos + 1'b1;
      end
   end

   AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= LAST_POS);                                               // R1
   AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (line >= LINE_ONE) && (line <= LINE_MAX));                      // R1
   AST_EAV_REPHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (realign && trs_eav) |=> (pos == EAV_NEXT));                    // R4
   AST_RESET_LOAD: assert property (@(posedge clk)
      !rst_n |=> ((pos == '0) && (line == LINE_ONE)));                // R7
endmodule

// File: rtl/vfw_lock_ctrl.sv
module vfw_lock_ctrl
   import vfw_pkg::*;
#(
   parameter int unsigned MISS_LINES = 4,
   parameter int unsigned LOCK_LINES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fast_lock,
   input  trs_evt_t evt,
   input  logic     pos_match,
   output logic     realign,
   output logic     locked
);
   localparam int unsigned MW = $clog2(MISS_LINES + 1);
   localparam int unsigned KW = $clog2(LOCK_LINES + 1);
   localparam logic [MW-1:0] MISS_TOP = MW'(MISS_LINES - 1);
   localparam logic [KW-1:0] LOCK_TOP = KW'(LOCK_LINES - 1);

   logic          fl_q, rise, arm, eav_ev, fast_hit, filt_hit;
   logic [MW-1:0] miss_cnt;
   logic [KW-1:0] match_cnt;

   // edge detector sees the pin in every cycle, reset or not
   always_ff @(posedge clk) fl_q <= fast_lock;

   assign rise     = fast_lock && !fl_q;
   assign eav_ev   = evt.valid && evt.eav;
   assign fast_hit = arm && evt.valid;
   assign filt_hit = !arm && eav_ev && !pos_match && (miss_cnt == MISS_TOP);
   assign realign  = fast_hit || filt_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm       <= 1'b0;
         miss_cnt  <= '0;
         match_cnt <= '0;
         locked    <= 1'b0;
      end else begin
         if (rise)          arm <= 1'b1;
         else if (fast_hit) arm <= 1'b0;

         if (realign) begin
            miss_cnt  <= '0;
            match_cnt <= '0;
            locked    <= 1'b0;
         end else if (eav_ev) begin
            if (pos_match) begin
               miss_cnt  <= '0;
               match_cnt <= (match_cnt == LOCK_TOP) ? match_cnt : match_cnt + 1'b1;
               if (match_cnt == LOCK_TOP) locked <= 1'b1;
            end else begin
               miss_cnt  <= miss_cnt + 1'b1;
               match_cnt <= '0;
               locked    <= 1'b0;
            end
         end
      end
   end

   AST_LOCK_DROPS_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (eav_ev && !pos_match) |=> !locked);                            // R5
   AST_FAST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && evt.valid && !rise) |=> !arm);                          // R6
endmodule

// File: rtl/video_flywheel.sv
module video_flywheel
   import vfw_pkg::*;
#(
   parameter int unsigned TOTAL_SAMPLES     = 1650,
   parameter int unsigned ACTIVE_SAMPLES    = 1280,
   parameter int unsigned TOTAL_LINES       = 750,
   parameter int unsigned FIRST_ACTIVE_LINE = 26,
   parameter int unsigned LAST_ACTIVE_LINE  = 745,
   parameter int unsigned MISS_LINES        = 4,
   parameter int unsigned LOCK_LINES        = 2,
   parameter bit          INTERLACED        = 1'b0,
   parameter int unsigned FIELD2_LINE       = 376,
   localparam int unsigned DW = 2 * WORD_W,
   localparam int unsigned SW = $clog2(TOTAL_SAMPLES),
   localparam int unsigned LW = $clog2(TOTAL_LINES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fast_lock,
   input  logic [DW-1:0] data_in,
   output logic [DW-1:0] data_out,
   output logic          h_blank,
   output logic          v_blank,
   output logic          field,
   output logic [LW-1:0] line_num,
   output logic [SW-1:0] sample_pos,
   output logic          locked
);
   localparam logic [SW-1:0] H_START = SW'(ACTIVE_SAMPLES);
   localparam logic [LW-1:0] V_FIRST = LW'(FIRST_ACTIVE_LINE);
   localparam logic [LW-1:0] V_LAST  = LW'(LAST_ACTIVE_LINE);

   if (ACTIVE_SAMPLES + 8 > TOTAL_SAMPLES) begin : g_bad_samples
      $error("line too short for two reference codes");
   end
   if ((FIRST_ACTIVE_LINE < 1) || (FIRST_ACTIVE_LINE > LAST_ACTIVE_LINE)
       || (LAST_ACTIVE_LINE > TOTAL_LINES)) begin : g_bad_lines
      $error("active line window outside the frame");
   end
   if ((MISS_LINES < 1) || (LOCK_LINES < 1)) begin : g_bad_counts
      $error("filter depth and lock count must be at least one");
   end

   trs_evt_t      evt;
   logic          pos_match, realign, f_next;
   logic [SW-1:0] pos;
   logic [LW-1:0] line;

   vfw_trs_detect u_detect (
      .clk  (clk),
      .luma (data_in[DW-1:WORD_W]),
      .evt  (evt)
   );

   vfw_raster #(
      .TOTAL_SAMPLES  (TOTAL_SAMPLES),
      .ACTIVE_SAMPLES (ACTIVE_SAMPLES),
      .TOTAL_LINES    (TOTAL_LINES)
   ) u_raster (
      .clk       (clk),
      .rst_n     (rst_n),
      .realign   (realign),
      .trs_eav   (evt.eav),
      .pos_match (pos_match),
      .pos       (pos),
      .line      (line)
   );

   vfw_lock_ctrl #(
      .MISS_LINES (MISS_LINES),
      .LOCK_LINES (LOCK_LINES)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .fast_lock (fast_lock),
      .evt       (evt),
      .pos_match (pos_match),
      .realign   (realign),
      .locked    (locked)
   );

   if (INTERLACED) begin : g_field_interlaced
      assign f_next = (line >= LW'(FIELD2_LINE));
   end else begin : g_field_progressive
      assign f_next = 1'b0;
   end

   // word delay stays live through reset
   always_ff @(posedge clk) data_out <= data_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_blank    <= 1'b0;
         v_blank    <= 1'b0;
         field      <= 1'b0;
         line_num   <= LW'(1);
         sample_pos <= '0;
      end else begin
         h_blank    <= (pos >= H_START);
         v_blank    <= (line < V_FIRST) || (line > V_LAST);
         field      <= f_next;
         line_num   <= line;
         sample_pos <= pos;
      end
   end
endmodule

// File: tb/video_flywheel_tb.sv
module video_flywheel_tb;
   localparam int T  = 40;
   localparam int A  = 24;
   localparam int L  = 12;
   localparam int V1 = 3;
   localparam int V2 = 10;
   localparam int ROWS = 15;

   // row: [15:8] phase jump, [7] fast_lock level, [6] corrupt codes,
   //      [5:2] source lines, [1] expect aligned, [0] expect locked
   localparam logic [15:0] TBL [ROWS] = '{
      {8'd0,  1'b0, 1'b0, 4'd3, 1'b1, 1'b1},
      {8'd7,  1'b0, 1'b0, 4'd3, 1'b0, 1'b0},
      {8'd0,  1'b0, 1'b0, 4'd1, 1'b1, 1'b0},
      {8'd0,  1'b0, 1'b0, 4'd2, 1'b1, 1'b1},
      {8'd3,  1'b0, 1'b0, 4'd3, 1'b0, 1'b0},
      {8'd37, 1'b0, 1'b0, 4'd2, 1'b1, 1'b0},
      {8'd3,  1'b0, 1'b0, 4'd3, 1'b0, 1'b0},
      {8'd37, 1'b0, 1'b0, 4'd3, 1'b1, 1'b1},
      {8'd6,  1'b0, 1'b1, 4'd5, 1'b0, 1'b1},
      {8'd34, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1},
      {8'd0,  1'b1, 1'b0, 4'd2, 1'b1, 1'b0},
      {8'd5,  1'b1, 1'b0, 4'd3, 1'b0, 1'b0},
      {8'd0,  1'b0, 1'b0, 4'd1, 1'b1, 1'b0},
      {8'd9,  1'b1, 1'b0, 4'd1, 1'b1, 1'b0},
      {8'd0,  1'b0, 1'b0, 4'd2, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fast_lock = 1'b0;
   logic [19:0] data_in = '0;
   logic [19:0] data_out;
   logic        h_blank, v_blank, field, locked;
   logic [3:0]  line_num;
   logic [5:0]  sample_pos;

   int n_chk = 0, n_fail = 0;
   bit done = 0, synced = 0;
   int sp = 0, sl = 1, wraps = 0, last_sp = 0, last_sl = 1;
   logic [19:0] last_word;

   always #4 clk = ~clk;

   video_flywheel #(
      .TOTAL_SAMPLES (T), .ACTIVE_SAMPLES (A), .TOTAL_LINES (L),
      .FIRST_ACTIVE_LINE (V1), .LAST_ACTIVE_LINE (V2)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .fast_lock (fast_lock),
      .data_in (data_in), .data_out (data_out),
      .h_blank (h_blank), .v_blank (v_blank), .field (field),
      .line_num (line_num), .sample_pos (sample_pos), .locked (locked)
   );

   function automatic logic [9:0] status(input bit f, input bit v, input bit h, input bit bad);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h ^ bad, 2'b00};
   endfunction

   function automatic bit vblank_of(input int line);
      return (line < V1) || (line > V2);
   endfunction

   function automatic logic [19:0] src_word(input int p, input int line, input bit bad);
      logic [9:0] y;
      bit v;
      v = vblank_of(line);
      if (p == A || p == T - 4)                               y = 10'h3FF;
      else if (p == A + 1 || p == A + 2 || p == T - 3 || p == T - 2) y = 10'h000;
      else if (p == A + 3)                                    y = status(1'b0, v, 1'b1, bad);
      else if (p == T - 1)                                    y = status(1'b0, v, 1'b0, bad);
      else if (p < A && !v)                                   y = 10'h200 + 10'(p);
      else                                                    y = 10'h040;
      return {y, 10'h200};
   endfunction

   function automatic string row_tag(input int r);
      case (r)
         0:                 return "R3";
         1, 2, 4, 5, 6:     return "R4";
         3, 7, 14:          return "R5";
         8, 9:              return "R2";
         default:           return "R6";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic adv();
      if (synced) synced = 0;
      else @(negedge clk);
   endtask

   task automatic settle();
      @(negedge clk);
      synced = 1;
   endtask

   task automatic put(input bit bad);
      last_word = src_word(sp, sl, bad);
      data_in   = last_word;
      last_sp   = sp;
      last_sl   = sl;
      sp++;
      if (sp == T) begin
         sp = 0;
         sl = (sl == L) ? 1 : sl + 1;
         wraps++;
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      int e_h, e_v, e_ln, e_ps, e_f, e_d;
      bit have_prev;
      repeat (3) @(negedge clk);
      // reset state, R7
      chk(sample_pos == 0, "R7", "reset sample_pos", int'(sample_pos), 0);
      chk(line_num == 1, "R7", "reset line_num", int'(line_num), 1);
      chk(locked == 0, "R7", "reset locked", int'(locked), 0);

      // full frame from reset, compared word by word: R1, R8, R9
      rst_n = 1'b1;
      synced = 1;
      e_h = 0; e_v = 0; e_ln = 0; e_ps = 0; e_f = 0; e_d = 0;
      have_prev = 0;
      for (int k = 0; k <= T * L; k++) begin
         if (k < T * L) adv(); else settle();
         if (have_prev) begin
            if (h_blank != (last_sp >= A))          e_h++;
            if (v_blank != vblank_of(last_sl))      e_v++;
            if (int'(line_num) != last_sl)          e_ln++;
            if (int'(sample_pos) != last_sp)        e_ps++;
            if (field != 1'b0)                      e_f++;
            if (data_out != last_word)              e_d++;
         end
         if (k < T * L) begin
            put(1'b0);
            have_prev = 1;
         end
      end
      chk(e_ps == 0, "R1", "sample_pos errors", e_ps, 0);
      chk(e_ln == 0, "R1", "line_num errors", e_ln, 0);
      chk(e_h == 0, "R8", "h_blank errors", e_h, 0);
      chk(e_v == 0, "R8", "v_blank errors", e_v, 0);
      chk(e_d == 0, "R8", "data_out errors", e_d, 0);
      chk(e_f == 0, "R9", "field high in progressive", e_f, 0);
      chk(locked == 1, "R5", "locked after frame", int'(locked), 1);

      // stimulus table: phase jumps, corrupted codes, fast relock
      for (int r = 0; r < ROWS; r++) begin
         logic [15:0] row;
         bit first, al;
         row = TBL[r];
         wraps = 0;
         sp = (sp + int'(row[15:8])) % T;
         first = 1;
         while (wraps < int'(row[5:2])) begin
            adv();
            if (first) fast_lock = row[7];
            first = 0;
            put(row[6]);
         end
         settle();
         al = (int'(sample_pos) == last_sp);
         chk(al == row[1], row_tag(r), $sformatf("row %0d aligned", r), int'(al), int'(row[1]));
         chk(locked == row[0], row_tag(r), $sformatf("row %0d locked", r), int'(locked), int'(row[0]));
      end

      // reset in mid-line: R7
      for (int k = 0; k < 10; k++) begin
         adv();
         put(1'b0);
      end
      adv();
      rst_n = 1'b0;
      put(1'b0);
      settle();
      chk(sample_pos == 0, "R7", "sample_pos after mid-line reset", int'(sample_pos), 0);
      chk(line_num == 1, "R7", "line_num after mid-line reset", int'(line_num), 1);
      chk(locked == 0, "R7", "locked after mid-line reset", int'(locked), 0);
      chk(data_out == last_word, "R7", "data path during reset", int'(data_out), int'(last_word));
      adv();
      rst_n = 1'b1;
      sp = 0;
      sl = 1;
      put(1'b0);
      adv();
      put(1'b0);
      settle();
      chk(sample_pos == 1, "R7", "count restarts after reset", int'(sample_pos), 1);

      done = 1;
      finish_run();
   end
endmodule